// File: doc/BRIEF.md
# Scalar Register Busy Scoreboard

This block keeps one busy flag for every physical scalar register of a compute unit. The issue stage presents a candidate instruction as a bundle of decoded operands. Each operand has a valid flag, a source flag, a destination flag, a logical register index and a byte size. The block answers combinationally whether every register read by that instruction is free. When the issue stage commits the instruction, it raises a schedule strobe, and every register the instruction will write becomes busy. When the instruction later executes, the block learns its class. Plain ALU work frees its destinations after a fixed pipeline latency. Loads and returning atomics keep their destinations busy until a separate write-back bundle reports that their data has arrived, and the registers free one clock after that.

Each wavefront owns a base register loaded at launch. A logical index is turned into a physical one by adding that base, and the sum wraps around the register file. An operand wider than one dword covers several consecutive registers. The block also keeps a read counter in dwords, a write counter in registers, and one read-after-write stall counter for each wavefront.

Top module: `sreg_scoreboard`

## Requirements
- R1: After reset, all busy flags are clear, the read, write and stall counters are zero, and every wavefront base is zero.
- R2: An operand of 4 bytes or less covers one register. A larger operand covers size/4 consecutive registers, capped at MAX_DW, starting at its mapped index.
- R3: The physical index is (base[wavefront] + logical index + k) modulo NUM_REGS. A base written with `base_we` is used from the next cycle onward.
- R4: `iss_ready` is 1 exactly when no register covered by a valid operand with its source flag set is busy. Operands that are only destinations are ignored by this check.
- R5: A cycle with `iss_sched` high sets the busy flag of every register covered by the valid destination operands of the issue bundle. The flags are visible after that clock edge.
- R6: An execute with class 0 (ALU) clears its destination registers after the clock edge that lies PIPE_LAT edges after the execute edge. The registers stay busy before that edge.
- R7: An execute with class 1 (load), 2 (atomic) or 3 (memory sync) leaves the busy flags unchanged. A write-back clears the registers of its bundle after the edge following the write-back edge.
- R8: When a set and a release hit the same register in the same cycle, the register stays busy.
- R9: On each execute, of any class, `rd_cnt` grows by the dword count of the valid source operands.
- R10: `wr_cnt` grows by the destination register count on each ALU execute and on each write-back. It does not change on a non-ALU execute.
- R11: A cycle with `iss_check` high and `iss_ready` low increments the stall counter of `iss_wid`. Wavefront w occupies bits [w*CNT_W +: CNT_W] of `stall_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load a wavefront base register |
| base_wid | input | WID_W | Wavefront whose base is loaded |
| base_val | input | IDX_W | New base value |
| iss_wid | input | WID_W | Wavefront of the issue candidate |
| iss_op_vld | input | MAX_OPS | Operand valid flags |
| iss_op_src | input | MAX_OPS | Operand is read |
| iss_op_dst | input | MAX_OPS | Operand is written |
| iss_op_idx | input | MAX_OPS*IDX_W | Logical indices, operand o at [o*IDX_W +: IDX_W] |
| iss_op_size | input | MAX_OPS*SZ_W | Byte sizes, operand o at [o*SZ_W +: SZ_W] |
| iss_check | input | 1 | Readiness is being tested this cycle |
| iss_sched | input | 1 | Candidate is committed; set its destinations busy |
| iss_ready | output | 1 | All source registers are free |
| ex_valid | input | 1 | An instruction executes |
| ex_class | input | 2 | 0 ALU, 1 load, 2 atomic, 3 memory sync |
| ex_wid | input | WID_W | Wavefront of the executing instruction |
| ex_op_vld | input | MAX_OPS | Operand valid flags |
| ex_op_src | input | MAX_OPS | Operand is read |
| ex_op_dst | input | MAX_OPS | Operand is written |
| ex_op_idx | input | MAX_OPS*IDX_W | Logical indices |
| ex_op_size | input | MAX_OPS*SZ_W | Byte sizes |
| wb_valid | input | 1 | Load or atomic data written back |
| wb_wid | input | WID_W | Wavefront of the write-back |
| wb_op_vld | input | MAX_OPS | Destination operand valid flags |
| wb_op_idx | input | MAX_OPS*IDX_W | Logical indices |
| wb_op_size | input | MAX_OPS*SZ_W | Byte sizes |
| busy | output | NUM_REGS | Busy flag for each physical register |
| rd_cnt | output | CNT_W | Dwords read |
| wr_cnt | output | CNT_W | Registers written |
| stall_cnt | output | NUM_WAVES*CNT_W | Read-after-write stalls for each wavefront |

## Verification
The bench goes after the exact release edge of an ALU result: a pipe one stage short would free a register a cycle early and let a dependent read through. It also checks that a load keeps its registers through execute and through the write-back edge itself; a design that freed them at execute would break a read-after-load. A base close to the top of the file makes a wide operand wrap around to register 0, and a design without the modulo would set flags past the end or miss the low registers. A schedule in the very cycle a release lands must leave the register busy, otherwise a new producer's result would look free. Destination-only operands sit on busy registers to show that they never stall the issue stage.

// File: rtl/sreg_sb_pkg.sv
package sreg_sb_pkg;

    typedef enum logic [1:0] {
        CLS_ALU    = 2'd0,
        CLS_LOAD   = 2'd1,
        CLS_ATOMIC = 2'd2,
        CLS_SYNC   = 2'd3
    } exec_class_e;

    // Number of consecutive registers an operand of the given byte size covers
    function automatic int op_regs(input int bytes, input int max_dw);
        int n;
        n = (bytes <= 4) ? 1 : (bytes / 4);
        if (n > max_dw) n = max_dw;
        return n;
    endfunction

endpackage

// File: rtl/sreg_base_table.sv
module sreg_base_table #(
    parameter int NUM_WAVES = 4,
    parameter int IDX_W     = 7,
    parameter int NRD       = 3,
    localparam int WID_W    = $clog2(NUM_WAVES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [WID_W-1:0]       wr_wid,
    input  logic [IDX_W-1:0]       wr_val,
    input  logic [NRD*WID_W-1:0]   rd_wid,
    output logic [NRD*IDX_W-1:0]   rd_base
);

    logic [IDX_W-1:0] tbl [NUM_WAVES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WAVES; w++) tbl[w] <= '0;
        end else if (we) begin
            tbl[wr_wid] <= wr_val;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_base[r*IDX_W +: IDX_W] = tbl[rd_wid[r*WID_W +: WID_W]];
    end

endmodule

// File: rtl/sreg_opnd_mask.sv
module sreg_opnd_mask
    import sreg_sb_pkg::*;
#(
    parameter int NUM_REGS = 128,
    parameter int MAX_OPS  = 4,
    parameter int MAX_DW   = 4,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int SZ_W    = $clog2(4*MAX_DW + 1)
) (
    input  logic [IDX_W-1:0]         base,
    input  logic [MAX_OPS-1:0]       sel,
    input  logic [MAX_OPS*IDX_W-1:0] idx,
    input  logic [MAX_OPS*SZ_W-1:0]  size,
    output logic [NUM_REGS-1:0]      mask
);

    always_comb begin
        mask = '0;
        for (int o = 0; o < MAX_OPS; o++) begin
            if (sel[o]) begin
                for (int j = 0; j < MAX_DW; j++) begin
                    if (j < op_regs(int'(size[o*SZ_W +: SZ_W]), MAX_DW)) begin
                        mask[base + idx[o*IDX_W +: IDX_W] + IDX_W'(j)] = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sreg_opnd_count.sv
module sreg_opnd_count
    import sreg_sb_pkg::*;
#(
    parameter int MAX_OPS = 4,
    parameter int MAX_DW  = 4,
    localparam int SZ_W   = $clog2(4*MAX_DW + 1),
    localparam int CW     = $clog2(MAX_OPS*MAX_DW + 1)
) (
    input  logic [MAX_OPS-1:0]      sel,
    input  logic [MAX_OPS*SZ_W-1:0] size,
    output logic [CW-1:0]           cnt
);

    always_comb begin
        cnt = '0;
        for (int o = 0; o < MAX_OPS; o++) begin
            if (sel[o]) cnt = cnt + CW'(op_regs(int'(size[o*SZ_W +: SZ_W]), MAX_DW));
        end
    end

endmodule

// File: rtl/sreg_release_pipe.sv
module sreg_release_pipe #(
    parameter int NUM_REGS = 128,
    parameter int LAT      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] in_mask,
    output logic [NUM_REGS-1:0] out_mask
);

    logic [NUM_REGS-1:0] stage [LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) stage[k] <= '0;
        end else begin
            stage[0] <= in_mask;
            for (int k = 1; k < LAT; k++) stage[k] <= stage[k-1];
        end
    end

    assign out_mask = stage[LAT-1];

endmodule

// File: rtl/sreg_scoreboard.sv
module sreg_scoreboard
    import sreg_sb_pkg::*;
#(
    parameter int NUM_REGS  = 128,
    parameter int NUM_WAVES = 4,
    parameter int MAX_OPS   = 4,
    parameter int MAX_DW    = 4,
    parameter int PIPE_LAT  = 4,
    parameter int CNT_W     = 32,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int WID_W    = $clog2(NUM_WAVES),
    localparam int SZ_W     = $clog2(4*MAX_DW + 1),
    localparam int CW       = $clog2(MAX_OPS*MAX_DW + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       base_we,
    input  logic [WID_W-1:0]           base_wid,
    input  logic [IDX_W-1:0]           base_val,
    input  logic [WID_W-1:0]           iss_wid,
    input  logic [MAX_OPS-1:0]         iss_op_vld,
    input  logic [MAX_OPS-1:0]         iss_op_src,
    input  logic [MAX_OPS-1:0]         iss_op_dst,
    input  logic [MAX_OPS*IDX_W-1:0]   iss_op_idx,
    input  logic [MAX_OPS*SZ_W-1:0]    iss_op_size,
    input  logic                       iss_check,
    input  logic                       iss_sched,
    output logic                       iss_ready,
    input  logic                       ex_valid,
    input  logic [1:0]                 ex_class,
    input  logic [WID_W-1:0]           ex_wid,
    input  logic [MAX_OPS-1:0]         ex_op_vld,
    input  logic [MAX_OPS-1:0]         ex_op_src,
    input  logic [MAX_OPS-1:0]         ex_op_dst,
    input  logic [MAX_OPS*IDX_W-1:0]   ex_op_idx,
    input  logic [MAX_OPS*SZ_W-1:0]    ex_op_size,
    input  logic                       wb_valid,
    input  logic [WID_W-1:0]           wb_wid,
    input  logic [MAX_OPS-1:0]         wb_op_vld,
    input  logic [MAX_OPS*IDX_W-1:0]   wb_op_idx,
    input  logic [MAX_OPS*SZ_W-1:0]    wb_op_size,
    output logic [NUM_REGS-1:0]        busy,
    output logic [CNT_W-1:0]           rd_cnt,
    output logic [CNT_W-1:0]           wr_cnt,
    output logic [NUM_WAVES*CNT_W-1:0] stall_cnt
);

    // Base lookup: read port 0 issue, 1 execute, 2 write-back
    logic [3*IDX_W-1:0] bases;
    logic [IDX_W-1:0]   iss_base, ex_base, wb_base;

    sreg_base_table #(
        .NUM_WAVES (NUM_WAVES),
        .IDX_W     (IDX_W),
        .NRD       (3)
    ) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (base_we),
        .wr_wid  (base_wid),
        .wr_val  (base_val),
        .rd_wid  ({wb_wid, ex_wid, iss_wid}),
        .rd_base (bases)
    );

    assign iss_base = bases[0*IDX_W +: IDX_W];
    assign ex_base  = bases[1*IDX_W +: IDX_W];
    assign wb_base  = bases[2*IDX_W +: IDX_W];

    // Operand footprints
    logic [NUM_REGS-1:0] iss_src_m, iss_dst_m, ex_dst_m, wb_dst_m;
    logic [CW-1:0]       ex_src_cnt, ex_dst_cnt, wb_dst_cnt;

    sreg_opnd_mask #(.NUM_REGS(NUM_REGS), .MAX_OPS(MAX_OPS), .MAX_DW(MAX_DW)) u_m_iss_src (
        .base(iss_base), .sel(iss_op_vld & iss_op_src), .idx(iss_op_idx), .size(iss_op_size), .mask(iss_src_m));
    sreg_opnd_mask #(.NUM_REGS(NUM_REGS), .MAX_OPS(MAX_OPS), .MAX_DW(MAX_DW)) u_m_iss_dst (
        .base(iss_base), .sel(iss_op_vld & iss_op_dst), .idx(iss_op_idx), .size(iss_op_size), .mask(iss_dst_m));
    sreg_opnd_mask #(.NUM_REGS(NUM_REGS), .MAX_OPS(MAX_OPS), .MAX_DW(MAX_DW)) u_m_ex_dst (
        .base(ex_base), .sel(ex_op_vld & ex_op_dst), .idx(ex_op_idx), .size(ex_op_size), .mask(ex_dst_m));
    sreg_opnd_mask #(.NUM_REGS(NUM_REGS), .MAX_OPS(MAX_OPS), .MAX_DW(MAX_DW)) u_m_wb_dst (
        .base(wb_base), .sel(wb_op_vld), .idx(wb_op_idx), .size(wb_op_size), .mask(wb_dst_m));

    sreg_opnd_count #(.MAX_OPS(MAX_OPS), .MAX_DW(MAX_DW)) u_c_ex_src (
        .sel(ex_op_vld & ex_op_src), .size(ex_op_size), .cnt(ex_src_cnt));
    sreg_opnd_count #(.MAX_OPS(MAX_OPS), .MAX_DW(MAX_DW)) u_c_ex_dst (
        .sel(ex_op_vld & ex_op_dst), .size(ex_op_size), .cnt(ex_dst_cnt));
    sreg_opnd_count #(.MAX_OPS(MAX_OPS), .MAX_DW(MAX_DW)) u_c_wb_dst (
        .sel(wb_op_vld), .size(wb_op_size), .cnt(wb_dst_cnt));

    // Release scheduling
    exec_class_e         ex_cls;
    logic                ex_alu;
    logic [NUM_REGS-1:0] rel_alu_in, rel_ld_in, rel_alu, rel_ld, sched_m;

    assign ex_cls     = exec_class_e'(ex_class);
    assign ex_alu     = ex_valid && (ex_cls == CLS_ALU);
    assign rel_alu_in = ex_alu   ? ex_dst_m  : '0;
    assign rel_ld_in  = wb_valid ? wb_dst_m  : '0;
    assign sched_m    = iss_sched ? iss_dst_m : '0;

    sreg_release_pipe #(.NUM_REGS(NUM_REGS), .LAT(PIPE_LAT)) u_alu_pipe (
        .clk(clk), .rst_n(rst_n), .in_mask(rel_alu_in), .out_mask(rel_alu));
    sreg_release_pipe #(.NUM_REGS(NUM_REGS), .LAT(1)) u_ld_pipe (
        .clk(clk), .rst_n(rst_n), .in_mask(rel_ld_in), .out_mask(rel_ld));

    // Busy flags: a set in the same cycle overrides a release
    logic [NUM_REGS-1:0] busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= (busy_q & ~(rel_alu | rel_ld)) | sched_m;
    end

    assign busy      = busy_q;
    assign iss_ready = ~|(busy_q & iss_src_m);

    // Traffic counters
    logic [CNT_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] alu_wr, ld_wr;

    assign alu_wr = ex_alu   ? CNT_W'(ex_dst_cnt) : '0;
    assign ld_wr  = wb_valid ? CNT_W'(wb_dst_cnt) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            wr_q <= '0;
        end else begin
            if (ex_valid) rd_q <= rd_q + CNT_W'(ex_src_cnt);
            wr_q <= wr_q + alu_wr + ld_wr;
        end
    end

    assign rd_cnt = rd_q;
    assign wr_cnt = wr_q;

    // Per-wavefront read-after-write stall counters
    for (genvar w = 0; w < NUM_WAVES; w++) begin : g_stall
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (iss_check && !iss_ready && (iss_wid == WID_W'(w)))
                cnt_q <= cnt_q + 1'b1;
        end
        assign stall_cnt[w*CNT_W +: CNT_W] = cnt_q;
    end

endmodule

// File: rtl/sreg_sb_chk.sv
module sreg_sb_chk #(
    parameter int NUM_REGS  = 128,
    parameter int NUM_WAVES = 4,
    parameter int CNT_W     = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_REGS-1:0]        busy,
    input logic [NUM_REGS-1:0]        sched_m,
    input logic [NUM_REGS-1:0]        rel_alu,
    input logic [NUM_REGS-1:0]        rel_ld,
    input logic                       iss_ready,
    input logic                       iss_check,
    input logic                       ex_valid,
    input logic [1:0]                 ex_class,
    input logic                       wb_valid,
    input logic [CNT_W-1:0]           rd_cnt,
    input logic [CNT_W-1:0]           wr_cnt,
    input logic [NUM_WAVES*CNT_W-1:0] stall_cnt
);

    AST_STALL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_ready |-> (|busy)); // R4

    AST_SCHED_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|sched_m) |=> ((busy & $past(sched_m)) == $past(sched_m))); // R5

    AST_ALU_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel_alu) |=> ((busy & $past(rel_alu) & ~$past(sched_m)) == '0)); // R6

    AST_LOAD_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel_ld) |=> ((busy & $past(rel_ld) & ~$past(sched_m)) == '0)); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|((rel_alu | rel_ld) & sched_m)) |=>
            ((busy & $past((rel_alu | rel_ld) & sched_m)) == $past((rel_alu | rel_ld) & sched_m))); // R8

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |=> $stable(rd_cnt)); // R9

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wb_valid && !(ex_valid && ex_class == 2'd0)) |=> $stable(wr_cnt)); // R10

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_check |=> $stable(stall_cnt)); // R11

endmodule

bind sreg_scoreboard sreg_sb_chk #(
    .NUM_REGS  (NUM_REGS),
    .NUM_WAVES (NUM_WAVES),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_q),
    .sched_m   (sched_m),
    .rel_alu   (rel_alu),
    .rel_ld    (rel_ld),
    .iss_ready (iss_ready),
    .iss_check (iss_check),
    .ex_valid  (ex_valid),
    .ex_class  (ex_class),
    .wb_valid  (wb_valid),
    .rd_cnt    (rd_cnt),
    .wr_cnt    (wr_cnt),
    .stall_cnt (stall_cnt)
);

// File: tb/sreg_scoreboard_tb.sv
`timescale 1ns/1ps
module sreg_scoreboard_tb;

    localparam int NR   = 128;
    localparam int NW   = 4;
    localparam int NO   = 4;
    localparam int LAT  = 4;
    localparam int IW   = 7;
    localparam int SW   = 5;
    localparam int CNTW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic            base_we;
    logic [1:0]      base_wid;
    logic [IW-1:0]   base_val;
    logic [1:0]      iss_wid;
    logic [NO-1:0]   iss_op_vld, iss_op_src, iss_op_dst;
    logic [NO*IW-1:0] iss_op_idx;
    logic [NO*SW-1:0] iss_op_size;
    logic            iss_check, iss_sched, iss_ready;
    logic            ex_valid;
    logic [1:0]      ex_class, ex_wid;
    logic [NO-1:0]   ex_op_vld, ex_op_src, ex_op_dst;
    logic [NO*IW-1:0] ex_op_idx;
    logic [NO*SW-1:0] ex_op_size;
    logic            wb_valid;
    logic [1:0]      wb_wid;
    logic [NO-1:0]   wb_op_vld;
    logic [NO*IW-1:0] wb_op_idx;
    logic [NO*SW-1:0] wb_op_size;
    logic [NR-1:0]   busy;
    logic [CNTW-1:0] rd_cnt, wr_cnt;
    logic [NW*CNTW-1:0] stall_cnt;

    sreg_scoreboard u_dut (
        .clk(clk), .rst_n(rst_n),
        .base_we(base_we), .base_wid(base_wid), .base_val(base_val),
        .iss_wid(iss_wid), .iss_op_vld(iss_op_vld), .iss_op_src(iss_op_src), .iss_op_dst(iss_op_dst),
        .iss_op_idx(iss_op_idx), .iss_op_size(iss_op_size),
        .iss_check(iss_check), .iss_sched(iss_sched), .iss_ready(iss_ready),
        .ex_valid(ex_valid), .ex_class(ex_class), .ex_wid(ex_wid),
        .ex_op_vld(ex_op_vld), .ex_op_src(ex_op_src), .ex_op_dst(ex_op_dst),
        .ex_op_idx(ex_op_idx), .ex_op_size(ex_op_size),
        .wb_valid(wb_valid), .wb_wid(wb_wid), .wb_op_vld(wb_op_vld),
        .wb_op_idx(wb_op_idx), .wb_op_size(wb_op_size),
        .busy(busy), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .stall_cnt(stall_cnt)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state
    bit [NR-1:0]  mbusy;
    bit [NR-1:0]  mpipe [LAT];
    bit [NR-1:0]  mld;
    int unsigned  mrd, mwr;
    int unsigned  mstall [NW];
    bit [IW-1:0]  mbase [NW];

    task automatic chk(input bit ok, input string tag, input logic [NR-1:0] act, input logic [NR-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nregs(input int bytes);
        int n;
        if (bytes <= 4) n = 1;
        else n = bytes / 4;
        if (n > 4) n = 4;
        return n;
    endfunction

    function automatic bit [NR-1:0] refmask(input bit [IW-1:0] base, input bit [NO-1:0] sel,
                                            input bit [NO*IW-1:0] idx, input bit [NO*SW-1:0] sz);
        bit [NR-1:0] m = '0;
        for (int o = 0; o < NO; o++) begin
            if (sel[o]) begin
                for (int j = 0; j < nregs(int'(sz[o*SW +: SW])); j++)
                    m[(int'(base) + int'(idx[o*IW +: IW]) + j) % NR] = 1'b1;
            end
        end
        return m;
    endfunction

    function automatic int refcnt(input bit [NO-1:0] sel, input bit [NO*SW-1:0] sz);
        int c = 0;
        for (int o = 0; o < NO; o++) if (sel[o]) c += nregs(int'(sz[o*SW +: SW]));
        return c;
    endfunction

    task automatic clear_in();
        base_we = 0; base_wid = 0; base_val = 0;
        iss_wid = 0; iss_op_vld = 0; iss_op_src = 0; iss_op_dst = 0;
        iss_op_idx = 0; iss_op_size = 0; iss_check = 0; iss_sched = 0;
        ex_valid = 0; ex_class = 0; ex_wid = 0; ex_op_vld = 0; ex_op_src = 0; ex_op_dst = 0;
        ex_op_idx = 0; ex_op_size = 0;
        wb_valid = 0; wb_wid = 0; wb_op_vld = 0; wb_op_idx = 0; wb_op_size = 0;
    endtask

    task automatic set_iss(input int o, input bit s, input bit d, input int idx, input int sz);
        iss_op_vld[o] = 1'b1; iss_op_src[o] = s; iss_op_dst[o] = d;
        iss_op_idx[o*IW +: IW] = IW'(idx); iss_op_size[o*SW +: SW] = SW'(sz);
    endtask

    task automatic set_ex(input int o, input bit s, input bit d, input int idx, input int sz);
        ex_op_vld[o] = 1'b1; ex_op_src[o] = s; ex_op_dst[o] = d;
        ex_op_idx[o*IW +: IW] = IW'(idx); ex_op_size[o*SW +: SW] = SW'(sz);
    endtask

    task automatic set_wb(input int o, input int idx, input int sz);
        wb_op_vld[o] = 1'b1;
        wb_op_idx[o*IW +: IW] = IW'(idx); wb_op_size[o*SW +: SW] = SW'(sz);
    endtask

    // One clock: check ready before the edge, advance the model, check after the edge
    task automatic tick();
        bit [NR-1:0] srcm, schm, alum, ldm;
        bit exp_rdy;
        #1;
        srcm = refmask(mbase[iss_wid], iss_op_vld & iss_op_src, iss_op_idx, iss_op_size);
        exp_rdy = ((mbusy & srcm) == '0);
        chk(iss_ready === exp_rdy, "R4 ready", NR'(iss_ready), NR'(exp_rdy));
        if (iss_check && !exp_rdy) mstall[iss_wid]++;
        schm = iss_sched ? refmask(mbase[iss_wid], iss_op_vld & iss_op_dst, iss_op_idx, iss_op_size) : '0;
        alum = (ex_valid && ex_class == 2'd0) ? refmask(mbase[ex_wid], ex_op_vld & ex_op_dst, ex_op_idx, ex_op_size) : '0;
        ldm  = wb_valid ? refmask(mbase[wb_wid], wb_op_vld, wb_op_idx, wb_op_size) : '0;
        if (ex_valid) mrd += refcnt(ex_op_vld & ex_op_src, ex_op_size);
        if (ex_valid && ex_class == 2'd0) mwr += refcnt(ex_op_vld & ex_op_dst, ex_op_size);
        if (wb_valid) mwr += refcnt(wb_op_vld, wb_op_size);
        mbusy = (mbusy & ~(mpipe[LAT-1] | mld)) | schm;
        for (int k = LAT-1; k > 0; k--) mpipe[k] = mpipe[k-1];
        mpipe[0] = alum;
        mld = ldm;
        if (base_we) mbase[base_wid] = base_val;
        @(posedge clk);
        @(negedge clk);
        chk(busy === mbusy, "R5 R6 R7 R8 busy", busy, mbusy);
        chk(rd_cnt === mrd, "R9 rd_cnt", NR'(rd_cnt), NR'(mrd));
        chk(wr_cnt === mwr, "R10 wr_cnt", NR'(wr_cnt), NR'(mwr));
        for (int w = 0; w < NW; w++)
            chk(stall_cnt[w*CNTW +: CNTW] === mstall[w], "R11 stall_cnt",
                NR'(stall_cnt[w*CNTW +: CNTW]), NR'(mstall[w]));
    endtask

    function automatic int pick_size();
        case ($urandom % 6)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            4: return 12;
            default: return 16;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        clear_in();
        mbusy = '0; mld = '0; mrd = 0; mwr = 0;
        for (int k = 0; k < LAT; k++) mpipe[k] = '0;
        for (int w = 0; w < NW; w++) begin mstall[w] = 0; mbase[w] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: reset state
        chk(busy === '0, "R1 busy after reset", busy, '0);
        chk(rd_cnt === '0 && wr_cnt === '0, "R1 counters after reset", NR'({rd_cnt, wr_cnt}), '0);
        chk(stall_cnt === '0, "R1 stall after reset", NR'(stall_cnt), '0);
        chk(iss_ready === 1'b1, "R1 ready after reset", NR'(iss_ready), 1);

        // R3 R2 R5: base 10 on wave 1, 8-byte destination at logical 2 -> phys 12,13
        base_we = 1; base_wid = 1; base_val = 10;
        tick(); clear_in();
        iss_wid = 1; set_iss(0, 0, 1, 2, 8); iss_sched = 1;
        tick(); clear_in();
        chk(busy === ((NR'(1) << 12) | (NR'(1) << 13)), "R2 R3 R5 two-dword set", busy,
            (NR'(1) << 12) | (NR'(1) << 13));

        // R4 R11: source on busy reg 13 stalls wave 1
        iss_wid = 1; set_iss(0, 1, 0, 3, 4); iss_check = 1;
        #1 chk(iss_ready === 1'b0, "R4 busy source stalls", NR'(iss_ready), 0);
        tick(); clear_in();
        chk(stall_cnt[1*CNTW +: CNTW] === 1, "R11 wave1 stall", NR'(stall_cnt[1*CNTW +: CNTW]), 1);

        // R4: destination-only operand on a busy reg does not stall
        iss_wid = 1; set_iss(0, 0, 1, 3, 4); set_iss(1, 1, 0, 5, 4); iss_check = 1;
        #1 chk(iss_ready === 1'b1, "R4 dst-only ignored", NR'(iss_ready), 1);
        tick(); clear_in();
        chk(stall_cnt[1*CNTW +: CNTW] === 1, "R11 no stall when ready", NR'(stall_cnt[1*CNTW +: CNTW]), 1);

        // R6 R9 R10: ALU execute frees 12,13 exactly PIPE_LAT edges later
        ex_valid = 1; ex_class = 0; ex_wid = 1; set_ex(0, 0, 1, 2, 8); set_ex(1, 1, 0, 0, 16);
        tick(); clear_in();
        chk(rd_cnt === 4, "R9 16-byte source reads 4 dwords", NR'(rd_cnt), 4);
        chk(wr_cnt === 2, "R10 ALU write count", NR'(wr_cnt), 2);
        repeat (LAT-1) tick();
        chk(busy[13:12] === 2'b11, "R6 still busy one edge before release", NR'(busy[13:12]), 3);
        tick();
        chk(busy[13:12] === 2'b00, "R6 released after PIPE_LAT", NR'(busy[13:12]), 0);

        // R7 R10: load keeps regs 120..123 busy until one edge after write-back
        iss_wid = 0; set_iss(0, 0, 1, 120, 16); iss_sched = 1;
        tick(); clear_in();
        ex_valid = 1; ex_class = 1; ex_wid = 0; set_ex(0, 0, 1, 120, 16);
        tick(); clear_in();
        repeat (LAT+1) tick();
        chk(busy[123:120] === 4'hf, "R7 load execute does not free", NR'(busy[123:120]), 'hf);
        chk(wr_cnt === 2, "R10 load execute adds no writes", NR'(wr_cnt), 2);
        wb_valid = 1; wb_wid = 0; set_wb(0, 120, 16);
        tick(); clear_in();
        chk(busy[123:120] === 4'hf, "R7 busy through write-back edge", NR'(busy[123:120]), 'hf);
        chk(wr_cnt === 6, "R10 write-back adds writes", NR'(wr_cnt), 6);
        tick();
        chk(busy[123:120] === 4'h0, "R7 freed one edge after write-back", NR'(busy[123:120]), 0);

        // R3 R2: wraparound from base 126 and a 2-byte operand covering one register
        base_we = 1; base_wid = 2; base_val = 126;
        tick(); clear_in();
        iss_wid = 2; set_iss(0, 0, 1, 0, 16); set_iss(1, 0, 1, 5, 2); iss_sched = 1;
        tick(); clear_in();
        chk(busy[127:126] === 2'b11 && busy[1:0] === 2'b11, "R3 wrap covers 126,127,0,1",
            NR'({busy[127:126], busy[1:0]}), 'hf);
        chk(busy[4:3] === 2'b01, "R2 2-byte operand covers one reg", NR'(busy[4:3]), 1);

        // R8: schedule lands on the same edge as an ALU release
        ex_valid = 1; ex_class = 0; ex_wid = 3; set_ex(0, 0, 1, 50, 4);
        tick(); clear_in();
        repeat (LAT-1) tick();
        iss_wid = 3; set_iss(0, 0, 1, 50, 4); iss_sched = 1;
        tick(); clear_in();
        chk(busy[50] === 1'b1, "R8 set wins over release", NR'(busy[50]), 1);

        // Random traffic against the model
        for (int c = 0; c < 600; c++) begin
            clear_in();
            if ($urandom % 20 == 0) begin
                base_we = 1; base_wid = 2'($urandom); base_val = IW'($urandom);
            end
            iss_wid = 2'($urandom);
            for (int o = 0; o < NO; o++)
                if ($urandom % 2) set_iss(o, 1'($urandom), 1'($urandom), int'($urandom % NR), pick_size());
            iss_check = 1'($urandom);
            iss_sched = ($urandom % 10) < 3;
            if ($urandom % 10 < 4) begin
                ex_valid = 1; ex_class = 2'($urandom); ex_wid = 2'($urandom);
                for (int o = 0; o < NO; o++)
                    if ($urandom % 2) set_ex(o, 1'($urandom), 1'($urandom), int'($urandom % NR), pick_size());
            end
            if ($urandom % 10 < 3) begin
                wb_valid = 1; wb_wid = 2'($urandom);
                for (int o = 0; o < NO; o++)
                    if ($urandom % 2) set_wb(o, int'($urandom % NR), pick_size());
            end
            tick();
        end
        clear_in();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule